// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for each beat of one read or write burst inside an already open row. A single-cycle start pulse captures an 8-bit starting column together with the burst length code and the burst order presented with it. From the next clock the block presents one column per cycle until the programmed number of beats has been issued or a stop input cuts the burst short. A memory controller places it beside its command logic. Row opening, bank selection, data transfer and read latency are handled elsewhere.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block that holds the start column. They wrap within that block either by incrementing (linear order) or by XOR with the beat number (interleaved order). The full-page setting walks all 256 columns of the row upward. It wraps from 255 to 0 and runs until it is stopped.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous active-low reset, `valid_o` and `last_o` are 0, and they stay 0 until a start pulse arrives.
- R2: When `start_i` is 1 at a clock edge, `valid_o` is 1 in the following cycle and `col_o` equals the sampled `start_col_i` (beat 0).
- R3: The length code `blen_i` selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and the reserved values 4, 5 and 6 give 1 beat. After the last beat `valid_o` returns to 0.
- R4: With `ilv_i` = 0 (linear) and a fixed length BL, beat i has upper bits equal to the start column above the low log2(BL) bits, and low bits equal to (start low bits + i) mod BL.
- R5: With `ilv_i` = 1 (interleaved) and a fixed length BL, beat i equals the start column with its low log2(BL) bits XORed with i.
- R6: Code 7 selects full page: beat i is (start column + i) mod 256 whatever the value of `ilv_i`, and the burst has no natural end.
- R7: `last_o` is 1 only on the final beat of a fixed-length burst and is never 1 during a full-page burst.
- R8: When `stop_i` is 1 at an edge while `valid_o` is 1 and `start_i` is 0, `valid_o` is 0 in the next cycle. When no burst is running, `stop_i` has no effect.
- R9: A start pulse during a burst abandons it and begins the new burst in the next cycle. A start takes priority over a stop in the same cycle.
- R10: The length code and order are sampled only with the start pulse. Changing `blen_i` or `ilv_i` during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, begins a new burst |
| start_col_i | input | 8 | Starting column, sampled with `start_i` |
| blen_i | input | 3 | Burst length code, sampled with `start_i` |
| ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| stop_i | input | 1 | Ends a running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The main function is driven with start columns whose low bits are nonzero, aligned and all-ones, under every length code and both orders. Comparing linear and interleaved at lengths 4 and 8 separates the two wrap rules, because they agree at lengths 1 and 2. Unaligned starts show that the upper bits stay fixed. A full-page run started near the top of the row checks the 255-to-0 wrap, the absence of a last flag and the fact that the order setting is ignored. Directed cases cover stop in mid-burst, stop while idle, restart, start with stop in the same cycle, mode changes during a burst and reset during a burst.

// File: rtl/bcs_pkg.sv
// Package: shared widths, length codes and the captured burst configuration.
// Assumes an 8-bit column (256 columns per row).
package bcs_pkg;

    localparam int COL_W    = 8;
    localparam int CODE_W   = 3;
    localparam int FIX_CODES = 4;   // codes 0..3 give fixed bursts of 2**code

    typedef enum logic [CODE_W-1:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_FULL = 3'd7
    } blen_code_e;

    typedef struct packed {
        logic             full;   // full-page burst
        logic             ilv;    // interleaved order
        logic [COL_W-1:0] mask;   // low bits that move within the burst
    } burst_cfg_t;

endpackage

// File: rtl/bcs_mode_decode.sv
// Module: bcs_mode_decode
// Turns a length code and an order bit into a burst configuration.
// Assumes codes below FIX_CODES are fixed lengths, code 7 is full page, and
// the reserved codes act as a single beat. Full page forces linear order.
module bcs_mode_decode
    import bcs_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              ilv_i,
    output burst_cfg_t        cfg_o
);

    logic [COL_W-1:0] fix_mask [FIX_CODES];

    // One mask per fixed code, (2**k)-1.
    for (genvar k = 0; k < FIX_CODES; k++) begin : g_mask
        assign fix_mask[k] = COL_W'((1 << k) - 1);
    end

    // Select the mask and flags for the presented code.
    always_comb begin
        cfg_o.full = (code_i == BLEN_FULL);
        cfg_o.ilv  = ilv_i & ~cfg_o.full;
        cfg_o.mask = '0;
        if (cfg_o.full) begin
            cfg_o.mask = '1;
        end else if (int'(code_i) < FIX_CODES) begin
            cfg_o.mask = fix_mask[code_i[1:0]];
        end
    end

endmodule

// File: rtl/bcs_beat_counter.sv
// Module: bcs_beat_counter
// Tracks whether a burst is running and which beat it is on.
// Assumes the captured configuration is stable while a burst runs; start
// has priority over stop, and stop over the natural end.
module bcs_beat_counter
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             full_i,
    input  logic [COL_W-1:0] mask_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic             last_o
);

    // Final beat of a fixed burst: beat index reached the mask value.
    assign last_o = active_o & ~full_i & (beat_o == mask_i);

    // Advance the beat index and close the burst on stop or final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            beat_o   <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            beat_o   <= '0;
        end else if (active_o) begin
            if (stop_i || last_o) begin
                active_o <= 1'b0;
                beat_o   <= '0;
            end else begin
                beat_o <= beat_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcs_addr_gen.sv
// Module: bcs_addr_gen
// Combines the start column and beat index into the beat's column.
// Assumes mask is 2**n-1 (all ones for full page) and beat never exceeds it.
module bcs_addr_gen
    import bcs_pkg::*;
(
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] lin_low;
    logic [COL_W-1:0] ilv_low;

    // Candidate low parts for both orders.
    assign lin_low = (base_i + beat_i) & cfg_i.mask;
    assign ilv_low = (base_i ^ beat_i) & cfg_i.mask;

    // Each bit: fixed from the base above the mask, else from the chosen order.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = cfg_i.mask[b] ? (cfg_i.ilv ? ilv_low[b] : lin_low[b])
                                        : base_i[b];
    end

endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Issues one column per cycle for a burst inside an open row.
// Assumes start_i is a pulse; length code and order are sampled with it.
module burst_col_seq
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] blen_i,
    input  logic              ilv_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o
);

    burst_cfg_t       cfg_d;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat;

    bcs_mode_decode u_dec (
        .code_i (blen_i),
        .ilv_i  (ilv_i),
        .cfg_o  (cfg_d)
    );

    // Capture start column and configuration on a start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            base_q <= '0;
        end else if (start_i) begin
            cfg_q  <= cfg_d;
            base_q <= start_col_i;
        end
    end

    bcs_beat_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .full_i   (cfg_q.full),
        .mask_i   (cfg_q.mask),
        .active_o (valid_o),
        .beat_o   (beat),
        .last_o   (last_o)
    );

    bcs_addr_gen u_addr (
        .base_i (base_q),
        .beat_i (beat),
        .cfg_i  (cfg_q),
        .col_o  (col_o)
    );

endmodule

// File: rtl/bcs_chk.sv
// Module: bcs_chk
// Port-level protocol checks for burst_col_seq, attached by bind.
// Keeps its own copy of the length code taken at each start.
module bcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] blen_i,
    input logic       stop_i,
    input logic [7:0] col_o,
    input logic       valid_o,
    input logic       last_o
);

    logic [2:0] code_q;

    // Record the length code of the running burst.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= 3'd0;
        else if (start_i) code_q <= blen_i;
    end

    // R2
    start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R3
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    // R7
    no_last_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && code_q == 3'd7) |-> !last_o);

    // R6
    full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && code_q == 3'd7 && !start_i && !stop_i)
        |=> (valid_o && col_o == 8'($past(col_o) + 8'd1)));

    // R4
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && code_q != 3'd7 && !last_o && !start_i && !stop_i)
        |=> (col_o[7:3] == $past(col_o[7:3])));

endmodule

bind burst_col_seq bcs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .blen_i  (blen_i),
    .stop_i  (stop_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       ilv_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int n_run = 0;
    int n_fail = 0;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    always #5 clk = ~clk;

    // Vector: {start column, length code, order}
    localparam int NV = 12;
    localparam logic [11:0] VECS [NV] = '{
        {8'h35, 3'd3, 1'b0}, {8'h35, 3'd3, 1'b1},
        {8'h35, 3'd2, 1'b0}, {8'h35, 3'd2, 1'b1},
        {8'h35, 3'd1, 1'b0}, {8'h35, 3'd0, 1'b1},
        {8'hA8, 3'd3, 1'b0}, {8'hFF, 3'd3, 1'b1},
        {8'hFF, 3'd2, 1'b0}, {8'h6E, 3'd2, 1'b1},
        {8'h42, 3'd5, 1'b1}, {8'h07, 3'd3, 1'b0}
    };

    function automatic int blen_of(input logic [2:0] code);
        return (code < 3'd4) ? (1 << code) : 1;
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] code,
                                           input logic ilv, input int i);
        logic [7:0] m;
        logic [7:0] lo;
        if (code == 3'd7) return 8'(s + i);
        m  = 8'(blen_of(code) - 1);
        lo = ilv ? ((s & m) ^ 8'(i)) : (8'((s & m) + 8'(i)) & m);
        return (s & ~m) | (lo & m);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulse start on a negedge; returns at the negedge showing beat 0.
    task automatic launch(input logic [7:0] c, input logic [2:0] code, input logic ilv);
        start_col_i = c; blen_i = code; ilv_i = ilv; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Check n beats of the burst and the idle cycle that follows.
    task automatic walk(input logic [7:0] c, input logic [2:0] code, input logic ilv,
                        input string req);
        int n;
        n = blen_of(code);
        for (int i = 0; i < n; i++) begin
            check(valid_o === 1'b1, {req, " valid"}, valid_o, 1);
            check(col_o === exp_col(c, code, ilv, i), {req, " col"}, col_o,
                  exp_col(c, code, ilv, i));
            check(last_o === (i == n - 1), "R7 last", last_o, (i == n - 1));
            @(negedge clk);
        end
        check(valid_o === 1'b0, "R3 end", valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(valid_o === 1'b0 && last_o === 1'b0, "R1", {valid_o, last_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o === 1'b0, "R1 idle", valid_o, 0);

        // Table walk: R2 R3 R4 R5 R7
        for (int v = 0; v < NV; v++) begin
            launch(VECS[v][11:4], VECS[v][3:1], VECS[v][0]);
            walk(VECS[v][11:4], VECS[v][3:1], VECS[v][0],
                 VECS[v][0] ? "R5" : "R4");
        end

        // R6 full page, interleave ignored, wraps past 255, no last
        launch(8'hFD, 3'd7, 1'b1);
        for (int i = 0; i < 300; i++) begin
            check(valid_o === 1'b1 && col_o === 8'(8'hFD + i), "R6", col_o, 8'(8'hFD + i));
            check(last_o === 1'b0, "R7 full", last_o, 0);
            if (i == 299) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        check(valid_o === 1'b0, "R8 full stop", valid_o, 0);

        // R8 stop in the middle of an 8-beat burst
        launch(8'h10, 3'd3, 1'b0);
        @(negedge clk); @(negedge clk);
        check(col_o === 8'h12, "R8 pre", col_o, 8'h12);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check(valid_o === 1'b0, "R8 mid", valid_o, 0);

        // R8 stop while idle has no effect
        stop_i = 1'b1;
        @(negedge clk); @(negedge clk);
        stop_i = 1'b0;
        check(valid_o === 1'b0 && last_o === 1'b0, "R8 idle", valid_o, 0);

        // R9 restart mid-burst, with stop in the same cycle
        launch(8'h20, 3'd3, 1'b0);
        @(negedge clk);
        stop_i = 1'b1;
        launch(8'h5B, 3'd2, 1'b1);
        stop_i = 1'b0;
        walk(8'h5B, 3'd2, 1'b1, "R9");

        // R10 mode change during a burst is ignored
        launch(8'h35, 3'd3, 1'b0);
        blen_i = 3'd0; ilv_i = 1'b1;
        walk(8'h35, 3'd3, 1'b0, "R10");

        // R1 reset during a burst
        launch(8'h90, 3'd7, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check(valid_o === 1'b0 && last_o === 1'b0, "R1 midreset", valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o === 1'b0, "R1 after", valid_o, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule